// File: doc/BRIEF.md
# Half-Duplex Transmit Retry Controller

This block decides, for an Ethernet MAC transmitter running shared-medium CSMA/CD, when a queued frame may go onto the wire. A frame is offered by holding `frame_req` high. Once accepted, the block waits out carrier sense and then pulses `tx_start` to the serialiser. A collision during transmission produces a one-cycle `tx_abort`. The frame then either waits a random number of slot times and retries, or it is given up with a `frame_drop` pulse. The serialiser reports a clean end of frame on `tx_done`.

The random wait after the n-th collision is r slot times, with 0 ≤ r < 2^min(n, k). A free-running 10-bit LFSR supplies r. Configuration selects k, from 10 bits down to a single bit. Further switches allow a single attempt only, retrying of collisions that arrive after the collision window, and a limit on total deferral time. Frame serialisation, FCS generation and the PHY attachment belong to other blocks.

Sizes are parameters: `SLOT_BITS` (512), `COLL_WIN` (512), `DEFER_LIMIT` (24288) and `MAX_RETRY` (16). Every time-based count advances only on cycles where `bit_tick` is high.

Top module: `hdx_tx_retry_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tx_start`, `tx_abort`, `frame_drop`, `retry_err` and `defer_err` are all 0.
- R2: If `frame_req` is high at a clock edge while idle, with `cfg_tx_en`=1 and `carrier_sense`=0, then `tx_start` is high for exactly one cycle after the second such edge.
- R3: With `cfg_tx_en`=0 no frame is accepted and `tx_start` stays low. Raising it later starts the waiting frame on the second edge.
- R4: While `carrier_sense` is high an accepted frame is held back. `tx_start` rises on the first edge at which `carrier_sense` is sampled low.
- R5: A `collision` sampled high during transmission gives a `tx_abort` pulse one cycle wide after that edge.
- R6: With `cfg_no_retry`=0 a colliding frame is retried `MAX_RETRY` times. On the collision of attempt `MAX_RETRY`+1, `frame_drop` pulses together with `tx_abort` and `retry_err` goes to 1.
- R7: With `cfg_no_retry`=1 the first collision drops the frame (`frame_drop` with `tx_abort`), with no retry and no `retry_err`.
- R8: A collision is late when at least `COLL_WIN` ticks have passed since `tx_start`. With `cfg_late_retry`=0 a late collision drops the frame. With 1 it is retried like an early one.
- R9: After the n-th collision of a frame (idle carrier, tick every cycle), `tx_start` returns 2 + r·`SLOT_BITS` cycles after `tx_abort`, with 0 ≤ r < 2^min(n,k). `cfg_bo_limit` codes 00, 01, 10, 11 give k = 10, 8, 4, 1.
- R10: With `cfg_defer_chk`=1, once more than `DEFER_LIMIT` ticks have been spent deferring to carrier, the block pulses `tx_abort` and `frame_drop` and sets `defer_err`. With the check off it defers without limit.
- R11: The deferral count is cleared when a frame is accepted and when a collision occurs during transmission.
- R12: `retry_err` and `defer_err` hold their value until the next `tx_start`, on which both are cleared.
- R13: `tx_done` during transmission ends the frame with no `tx_abort` or `frame_drop`, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_req | input | 1 | A frame is waiting to be sent (level) |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision seen on the medium |
| bit_tick | input | 1 | One bit time has elapsed |
| tx_done | input | 1 | Serialiser finished the frame |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_no_retry | input | 1 | Single attempt per frame |
| cfg_late_retry | input | 1 | Retry collisions after the window |
| cfg_defer_chk | input | 1 | Enable the deferral time limit |
| cfg_bo_limit | input | 2 | Back-off random width code |
| tx_start | output | 1 | Start-transmit pulse |
| tx_abort | output | 1 | Abort-transmit pulse |
| frame_drop | output | 1 | Frame given up pulse |
| retry_err | output | 1 | Retry count exhausted flag |
| defer_err | output | 1 | Excessive deferral flag |

## Verification
A frame accepted on an idle medium starts on the second edge after the request. A start held back by carrier follows one edge after carrier is sampled low. `tx_abort`, with any `frame_drop`, comes one edge after the collision is sampled. After a collision the next start comes 2 + r·`SLOT_BITS` cycles later, so the bench checks that the measured gap lies in the allowed range and is a whole number of slots past 2. The deferral abort with the limit on is due `DEFER_LIMIT`+3 cycles after the request. The bench drives inputs and samples outputs on falling edges and counts those edges from the stimulus, so each comparison falls on the exact cycle stated.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DEFER   = 2'd1,
    ST_TX      = 2'd2,
    ST_BACKOFF = 2'd3
  } tx_state_e;

  // number of random bits allowed by the back-off limit code
  function automatic int bo_width(input logic [1:0] code);
    case (code)
      2'b00:   return 10;
      2'b01:   return 8;
      2'b10:   return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
  parameter int          W     = 10,
  parameter logic [W-1:0] SEED = 10'h2A5,
  parameter int          TAP_A = 9,
  parameter int          TAP_B = 6
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = q[TAP_A] ^ q[TAP_B];

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/hdx_sat_cnt.sv
module hdx_sat_cnt #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic over
);
  localparam int W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] TOP = W'(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign over = (cnt == TOP);
endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff #(
  parameter int SLOT_BITS = 512,
  parameter int SW        = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] slots,
  input  logic          bit_tick,
  output logic          busy
);
  localparam int BW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [BW-1:0] LAST = BW'(SLOT_BITS - 1);

  logic [SW-1:0] slot_cnt;
  logic [BW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
      bit_cnt  <= '0;
    end else if (load) begin
      slot_cnt <= slots;
      bit_cnt  <= '0;
    end else if (bit_tick && slot_cnt != '0) begin
      if (bit_cnt == LAST) begin
        bit_cnt  <= '0;
        slot_cnt <= slot_cnt - 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign busy = (slot_cnt != '0);
endmodule

// File: rtl/hdx_tx_retry_ctrl.sv
module hdx_tx_retry_ctrl
  import hdx_pkg::*;
#(
  parameter int SLOT_BITS   = 512,
  parameter int COLL_WIN    = 512,
  parameter int DEFER_LIMIT = 24288,
  parameter int MAX_RETRY   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_req,
  input  logic       carrier_sense,
  input  logic       collision,
  input  logic       bit_tick,
  input  logic       tx_done,
  input  logic       cfg_tx_en,
  input  logic       cfg_no_retry,
  input  logic       cfg_late_retry,
  input  logic       cfg_defer_chk,
  input  logic [1:0] cfg_bo_limit,
  output logic       tx_start,
  output logic       tx_abort,
  output logic       frame_drop,
  output logic       retry_err,
  output logic       defer_err
);
  localparam int RND_W = 10;
  localparam int RW    = $clog2(MAX_RETRY + 1);

  tx_state_e      state;
  logic [RW-1:0]  retry_cnt;
  logic [RND_W-1:0] rnd;
  logic [RND_W-1:0] rnd_mask;
  logic           accept, defer_over, late_col, bo_busy, bo_load;
  logic           drop_now, exhausted;

  hdx_lfsr #(.W(RND_W), .SEED(10'h2A5), .TAP_A(9), .TAP_B(6)) u_lfsr (
    .clk(clk), .rst(rst), .q(rnd)
  );

  assign accept = (state == ST_IDLE) && frame_req && cfg_tx_en;

  hdx_sat_cnt #(.LIMIT(DEFER_LIMIT)) u_defer (
    .clk (clk),
    .rst (rst),
    .clr (accept || (state == ST_TX && collision)),
    .inc ((state == ST_DEFER) && carrier_sense && bit_tick),
    .over(defer_over)
  );

  hdx_sat_cnt #(.LIMIT(COLL_WIN - 1)) u_window (
    .clk (clk),
    .rst (rst),
    .clr (state != ST_TX),
    .inc ((state == ST_TX) && bit_tick),
    .over(late_col)
  );

  // mask of random bits for the attempt about to be retried
  always_comb begin
    int k;
    k = int'(retry_cnt) + 1;
    if (k > bo_width(cfg_bo_limit)) k = bo_width(cfg_bo_limit);
    for (int i = 0; i < RND_W; i++) rnd_mask[i] = (i < k);
  end

  assign exhausted = (retry_cnt == RW'(MAX_RETRY));
  assign drop_now  = cfg_no_retry || (late_col && !cfg_late_retry) || exhausted;
  assign bo_load   = (state == ST_TX) && collision && !drop_now;

  hdx_backoff #(.SLOT_BITS(SLOT_BITS), .SW(RND_W)) u_backoff (
    .clk     (clk),
    .rst     (rst),
    .load    (bo_load),
    .slots   (rnd & rnd_mask),
    .bit_tick(bit_tick),
    .busy    (bo_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      retry_cnt  <= '0;
      tx_start   <= 1'b0;
      tx_abort   <= 1'b0;
      frame_drop <= 1'b0;
      retry_err  <= 1'b0;
      defer_err  <= 1'b0;
    end else begin
      tx_start   <= 1'b0;
      tx_abort   <= 1'b0;
      frame_drop <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            retry_cnt <= '0;
            state     <= ST_DEFER;
          end
        end
        ST_DEFER: begin
          if (cfg_defer_chk && defer_over) begin
            tx_abort   <= 1'b1;
            frame_drop <= 1'b1;
            defer_err  <= 1'b1;
            state      <= ST_IDLE;
          end else if (!carrier_sense && cfg_tx_en) begin
            tx_start  <= 1'b1;
            retry_err <= 1'b0;
            defer_err <= 1'b0;
            state     <= ST_TX;
          end
        end
        ST_TX: begin
          if (collision) begin
            tx_abort <= 1'b1;
            if (drop_now) begin
              frame_drop <= 1'b1;
              if (!cfg_no_retry && exhausted && !(late_col && !cfg_late_retry))
                retry_err <= 1'b1;
              state <= ST_IDLE;
            end else begin
              retry_cnt <= retry_cnt + 1'b1;
              state     <= ST_BACKOFF;
            end
          end else if (tx_done) begin
            state <= ST_IDLE;
          end
        end
        ST_BACKOFF: begin
          if (!bo_busy) state <= ST_DEFER;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdx_tx_retry_ctrl_chk.sv
module hdx_tx_retry_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cfg_tx_en,
  input logic tx_start,
  input logic tx_abort,
  input logic frame_drop,
  input logic retry_err,
  input logic defer_err
);
  a_r1_start_abort_excl: assert property (@(posedge clk) disable iff (rst)
    !(tx_start && tx_abort));

  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
    !cfg_tx_en |=> !tx_start);

  a_r5_abort_one_cycle: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !tx_abort);

  a_r7_drop_with_abort: assert property (@(posedge clk) disable iff (rst)
    frame_drop |-> tx_abort);

  a_r6_retry_err_on_drop: assert property (@(posedge clk) disable iff (rst)
    $rose(retry_err) |-> frame_drop);

  a_r10_defer_err_on_drop: assert property (@(posedge clk) disable iff (rst)
    $rose(defer_err) |-> frame_drop);

  a_r12_retry_err_sticky: assert property (@(posedge clk) disable iff (rst)
    retry_err |=> (retry_err || tx_start));

  a_r12_defer_err_sticky: assert property (@(posedge clk) disable iff (rst)
    defer_err |=> (defer_err || tx_start));
endmodule

bind hdx_tx_retry_ctrl hdx_tx_retry_ctrl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .cfg_tx_en (cfg_tx_en),
  .tx_start  (tx_start),
  .tx_abort  (tx_abort),
  .frame_drop(frame_drop),
  .retry_err (retry_err),
  .defer_err (defer_err)
);

// File: tb/hdx_tx_retry_ctrl_tb_top.sv
module hdx_tx_retry_ctrl_tb_top;
  localparam int SLOT = 8, WIN = 16, DLIM = 40, MAXR = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, frame_req = 0, carrier_sense = 0, collision = 0, bit_tick = 1, tx_done = 0;
  logic cfg_tx_en = 1, cfg_no_retry = 0, cfg_late_retry = 0, cfg_defer_chk = 0;
  logic [1:0] cfg_bo_limit = 2'b11;
  logic tx_start, tx_abort, frame_drop, retry_err, defer_err;

  int checks = 0, errors = 0;
  bit done = 0;

  hdx_tx_retry_ctrl #(.SLOT_BITS(SLOT), .COLL_WIN(WIN), .DEFER_LIMIT(DLIM), .MAX_RETRY(MAXR)) dut_i (
    .clk(clk), .rst(rst), .frame_req(frame_req), .carrier_sense(carrier_sense),
    .collision(collision), .bit_tick(bit_tick), .tx_done(tx_done), .cfg_tx_en(cfg_tx_en),
    .cfg_no_retry(cfg_no_retry), .cfg_late_retry(cfg_late_retry), .cfg_defer_chk(cfg_defer_chk),
    .cfg_bo_limit(cfg_bo_limit), .tx_start(tx_start), .tx_abort(tx_abort),
    .frame_drop(frame_drop), .retry_err(retry_err), .defer_err(defer_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count falling edges until tx_start is seen; -1 if not within maxc
  task automatic wait_start(input int maxc, output int cyc);
    int n = 0;
    while (n < maxc) begin
      @(negedge clk);
      n++;
      if (tx_start) begin
        cyc = n;
        return;
      end
    end
    cyc = -1;
  endtask

  task automatic collide(output bit ab, output bit dr);
    collision = 1;
    @(negedge clk);
    collision = 0;
    ab = tx_abort;
    dr = frame_drop;
  endtask

  task automatic finish_frame(input string req);
    int c;
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
    frame_req = 0;
    chk(!tx_abort && !frame_drop, req, int'(tx_abort) + int'(frame_drop), 0);
    wait_start(5, c);
    chk(c == -1, req, c, -1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({tx_start, tx_abort, frame_drop, retry_err, defer_err} == 5'b0, "R1 in reset",
        int'({tx_start, tx_abort, frame_drop, retry_err, defer_err}), 0);
    rst = 0;
    @(negedge clk);
    chk({tx_start, tx_abort, frame_drop, retry_err, defer_err} == 5'b0, "R1 after reset",
        int'({tx_start, tx_abort, frame_drop, retry_err, defer_err}), 0);
  endtask

  task automatic t_start_basic();
    int c;
    frame_req = 1;
    wait_start(10, c);
    chk(c == 2, "R2 start latency", c, 2);
    @(negedge clk);
    chk(tx_start == 0, "R2 pulse width", int'(tx_start), 0);
    finish_frame("R13 clean end");
  endtask

  task automatic t_tx_disabled();
    int c;
    cfg_tx_en = 0;
    frame_req = 1;
    wait_start(30, c);
    chk(c == -1, "R3 disabled no start", c, -1);
    cfg_tx_en = 1;
    wait_start(10, c);
    chk(c == 2, "R3 start after enable", c, 2);
    finish_frame("R13 end after R3");
  endtask

  task automatic t_defer_crs();
    int c;
    carrier_sense = 1;
    frame_req = 1;
    wait_start(20, c);
    chk(c == -1, "R4 held by carrier", c, -1);
    carrier_sense = 0;
    wait_start(5, c);
    chk(c == 1, "R4 start after carrier drop", c, 1);
    finish_frame("R13 end after R4");
  endtask

  task automatic t_no_retry();
    int c;
    bit ab, dr;
    cfg_no_retry = 1;
    frame_req = 1;
    wait_start(10, c);
    repeat (3) @(negedge clk);
    collide(ab, dr);
    chk(ab, "R5 abort after collision", int'(ab), 1);
    chk(dr, "R7 drop on first collision", int'(dr), 1);
    frame_req = 0;
    @(negedge clk);
    chk(tx_abort == 0, "R5 abort one cycle", int'(tx_abort), 0);
    wait_start(40, c);
    chk(c == -1, "R7 no retry", c, -1);
    chk(retry_err == 0, "R7 no retry error", int'(retry_err), 0);
    cfg_no_retry = 0;
  endtask

  task automatic t_retry_limit();
    int c, starts;
    bit ab, dr, bad;
    cfg_bo_limit = 2'b11;
    frame_req = 1;
    wait_start(10, c);
    starts = 1;
    bad = 0;
    for (int i = 1; i <= MAXR; i++) begin
      collide(ab, dr);
      if (!ab || dr) bad = 1;
      wait_start(2 + SLOT + 4, c);
      if (c < 2 || c > 2 + SLOT || ((c - 2) % SLOT) != 0) begin
        chk(0, "R9 code 11 gap", c, 2 + SLOT);
      end
      if (c > 0) starts++;
    end
    chk(!bad, "R6 retried collisions keep frame", int'(bad), 0);
    chk(starts == MAXR + 1, "R6 attempt count", starts, MAXR + 1);
    collide(ab, dr);
    chk(ab && dr, "R6 drop at limit", int'(dr), 1);
    chk(retry_err == 1, "R6 retry error", int'(retry_err), 1);
    frame_req = 0;
    repeat (5) @(negedge clk);
    chk(retry_err == 1, "R12 retry error held", int'(retry_err), 1);
    frame_req = 1;
    wait_start(10, c);
    chk(c == 2 && retry_err == 0, "R12 cleared on start", int'(retry_err), 0);
    finish_frame("R13 end after R12");
  endtask

  task automatic t_late();
    int c;
    bit ab, dr;
    cfg_late_retry = 0;
    frame_req = 1;
    wait_start(10, c);
    repeat (WIN + 4) @(negedge clk);
    collide(ab, dr);
    chk(ab && dr, "R8 late collision dropped", int'(dr), 1);
    frame_req = 0;
    repeat (3) @(negedge clk);
    cfg_late_retry = 1;
    frame_req = 1;
    wait_start(10, c);
    repeat (WIN + 4) @(negedge clk);
    collide(ab, dr);
    chk(ab && !dr, "R8 late collision kept", int'(dr), 0);
    wait_start(2 + SLOT + 4, c);
    chk(c >= 2, "R8 late collision retried", c, 2);
    finish_frame("R13 end after R8");
    cfg_late_retry = 0;
  endtask

  task automatic t_backoff(input logic [1:0] code, input int kmax, input int ncol);
    int c, maxr, k, lim;
    bit ab, dr;
    cfg_bo_limit = code;
    frame_req = 1;
    wait_start(10, c);
    maxr = 0;
    for (int n = 1; n <= ncol; n++) begin
      collide(ab, dr);
      k = (n < kmax) ? n : kmax;
      lim = 2 + ((1 << k) - 1) * SLOT;
      wait_start(lim + 4, c);
      chk(c >= 2 && c <= lim && ((c - 2) % SLOT) == 0, "R9 back-off gap", c, lim);
      if (c > maxr) maxr = c;
    end
    chk(maxr > 2, "R9 nonzero random wait", maxr, 3);
    finish_frame("R13 end after R9");
  endtask

  task automatic t_defer_abort();
    int n;
    cfg_defer_chk = 1;
    carrier_sense = 1;
    frame_req = 1;
    n = 0;
    while (n < 3 * DLIM) begin
      @(negedge clk);
      n++;
      if (tx_abort) break;
    end
    chk(n == DLIM + 3, "R10 deferral abort time", n, DLIM + 3);
    chk(frame_drop && defer_err, "R10 drop and flag", int'(defer_err), 1);
    frame_req = 0;
    carrier_sense = 0;
    repeat (4) @(negedge clk);
    chk(defer_err == 1, "R12 defer flag held", int'(defer_err), 1);
    frame_req = 1;
    wait_start(10, n);
    chk(n == 2 && defer_err == 0, "R12 defer flag cleared", int'(defer_err), 0);
    finish_frame("R13 end after R10");
  endtask

  task automatic t_defer_off();
    int c, aborts;
    cfg_defer_chk = 0;
    carrier_sense = 1;
    frame_req = 1;
    aborts = 0;
    repeat (3 * DLIM) begin
      @(negedge clk);
      if (tx_abort) aborts++;
    end
    chk(aborts == 0, "R10 unlimited deferral", aborts, 0);
    carrier_sense = 0;
    wait_start(5, c);
    chk(c == 1, "R10 start after long deferral", c, 1);
    finish_frame("R13 end after R10 off");
  endtask

  task automatic t_defer_clear();
    int c, aborts;
    bit ab, dr;
    cfg_defer_chk = 1;
    cfg_bo_limit = 2'b11;
    carrier_sense = 1;
    frame_req = 1;
    repeat (30) @(negedge clk);
    chk(tx_abort == 0, "R11 cleared on accept", int'(tx_abort), 0);
    carrier_sense = 0;
    wait_start(5, c);
    chk(c == 1, "R11 first start", c, 1);
    collide(ab, dr);
    carrier_sense = 1;
    aborts = 0;
    repeat (35) begin
      @(negedge clk);
      if (tx_abort) aborts++;
    end
    chk(aborts == 0, "R11 cleared on collision", aborts, 0);
    carrier_sense = 0;
    wait_start(5, c);
    chk(c == 1, "R11 retry after deferral", c, 1);
    finish_frame("R13 end after R11");
    cfg_defer_chk = 0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_start_basic();
    t_tx_disabled();
    t_defer_crs();
    t_no_retry();
    t_retry_limit();
    t_late();
    t_backoff(2'b10, 4, 7);
    t_backoff(2'b00, 10, 6);
    t_defer_abort();
    t_defer_off();
    t_defer_clear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R13 actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule